// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This combinational unit decides where a single-cycle integer core fetches from next. It takes the current program counter, the two source register values, an immediate that has already been sign-extended, the 7-bit major opcode and the 3-bit funct3 field. It produces three outputs: the next fetch address, the return address that a jump writes to its destination register, and a flag that shows whether control flow was redirected.

The unit handles conditional branches, the direct jump (target is PC plus the immediate) and the register-indirect jump (target is the source register plus the immediate, with bit 0 cleared). Any other opcode falls through to the next sequential instruction. The unit does not extract immediates, does not write registers and raises no alignment exceptions.

Top module: `branch_jump_nextpc`

## Requirements
- R1: When `opcode_i` is not one of 1100011 (branch), 1101111 (direct jump) or 1100111 (register jump), `next_pc_o` equals `pc_i + 4` and `taken_o` is 0.
- R2: For opcode 1101111, `next_pc_o` equals `pc_i + imm_i` and `taken_o` is 1.
- R3: For opcode 1100111, `next_pc_o` equals `(rs1_i + imm_i)` with bit 0 forced to 0, and `taken_o` is 1.
- R4: `link_o` always equals `pc_i + 4`, computed from the PC before update and independent of `rs1_i`, `rs2_i` and `imm_i`.
- R5: For the branch opcode, funct3 000 is taken when `rs1_i == rs2_i` and funct3 001 is taken when they differ.
- R6: For the branch opcode, funct3 100 is taken when `rs1_i < rs2_i` as two's-complement values, and funct3 101 is taken when `rs1_i >= rs2_i` as two's-complement values, including equality.
- R7: For the branch opcode, funct3 110 is taken when `rs1_i < rs2_i` as unsigned values, and funct3 111 is taken when `rs1_i >= rs2_i` as unsigned values, including equality.
- R8: For the branch opcode, funct3 010 and 011 are never taken.
- R9: For the branch opcode, `next_pc_o` is `pc_i + imm_i` when `taken_o` is 1 and `pc_i + 4` when it is 0.
- R10: All address sums wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Address of the current instruction |
| rs1_i | input | 32 | First source register value |
| rs2_i | input | 32 | Second source register value |
| imm_i | input | 32 | Sign-extended immediate |
| opcode_i | input | 7 | Major opcode of the current instruction |
| funct3_i | input | 3 | Condition selector for branches |
| next_pc_o | output | 32 | Address to fetch next |
| link_o | output | 32 | Return address for jumps |
| taken_o | output | 1 | High when control flow is redirected |

## Verification
The unit holds no state, so any fault in its compare or select logic appears on `next_pc_o` and `taken_o` in the same evaluation that presents the operands. A flipped signed or unsigned decision shows up only at sign-boundary operand pairs. For that reason, the sweep crosses all eight funct3 values with operands at zero, one, the largest and smallest signed values, and all-ones. A dropped bit-0 clear on the register jump shows up only with odd sums, so those sums are driven on purpose.

// File: rtl/nxpc_pkg.sv
// Package: shared constants for the next-PC unit.
// Assumes a 7-bit major opcode and a 3-bit condition field.
package nxpc_pkg;
    localparam int OPC_W = 7;
    localparam int F3_W  = 3;

    localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
    localparam logic [OPC_W-1:0] OPC_JDIR   = 7'b1101111;
    localparam logic [OPC_W-1:0] OPC_JREG   = 7'b1100111;

    typedef enum logic [F3_W-1:0] {
        CND_EQ  = 3'b000,
        CND_NE  = 3'b001,
        CND_R2  = 3'b010,
        CND_R3  = 3'b011,
        CND_LT  = 3'b100,
        CND_GE  = 3'b101,
        CND_LTU = 3'b110,
        CND_GEU = 3'b111
    } cond_e;

    typedef enum logic [1:0] {
        SEL_SEQ    = 2'd0,
        SEL_PCREL  = 2'd1,
        SEL_REGREL = 2'd2
    } sel_e;
endpackage

// File: rtl/nxpc_compare.sv
// Module: nxpc_compare
// Produces equality and signed/unsigned less-than from one subtractor.
// Assumes two's-complement operands of width XLEN.
module nxpc_compare #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output logic            eq_o,
    output logic            lt_s_o,
    output logic            lt_u_o
);
    localparam int DW = XLEN + 1;

    logic [DW-1:0] diff;

    // Subtract with one extra bit; the top bit is the unsigned borrow.
    always_comb begin
        diff   = {1'b0, a_i} - {1'b0, b_i};
        eq_o   = (diff[XLEN-1:0] == '0);
        lt_u_o = diff[DW-1];
        lt_s_o = (a_i[XLEN-1] ^ b_i[XLEN-1]) ? a_i[XLEN-1] : diff[DW-1];
    end

    // Check that equal operands never report less-than.
    always_comb begin
        // R6
        eq_excl_chk: assert (!(eq_o && (lt_s_o || lt_u_o)))
            else $error("equal operands flagged less-than");
    end
endmodule

// File: rtl/nxpc_cond.sv
// Module: nxpc_cond
// Maps funct3 and the comparison flags to a branch decision.
// Assumes the flags come from nxpc_compare on rs1 and rs2.
module nxpc_cond
    import nxpc_pkg::*;
(
    input  logic [F3_W-1:0] funct3_i,
    input  logic            eq_i,
    input  logic            lt_s_i,
    input  logic            lt_u_i,
    output logic            take_o
);
    // Select the condition named by funct3; the reserved codes never take.
    always_comb begin
        unique case (cond_e'(funct3_i))
            CND_EQ:  take_o = eq_i;
            CND_NE:  take_o = !eq_i;
            CND_LT:  take_o = lt_s_i;
            CND_GE:  take_o = !lt_s_i;
            CND_LTU: take_o = lt_u_i;
            CND_GEU: take_o = !lt_u_i;
            default: take_o = 1'b0;
        endcase
    end

    // Check that the reserved condition codes stay inactive.
    always_comb begin
        // R8
        reserved_code_chk: assert (!(take_o && (funct3_i[2:1] == 2'b01)))
            else $error("reserved condition taken");
    end
endmodule

// File: rtl/nxpc_target.sv
// Module: nxpc_target
// Adds a base and an offset; optionally clears bit 0 of the sum.
// Assumes sums wrap at XLEN bits.
module nxpc_target #(
    parameter int XLEN      = 32,
    parameter bit CLEAR_LSB = 1'b0
) (
    input  logic [XLEN-1:0] base_i,
    input  logic [XLEN-1:0] ofs_i,
    output logic [XLEN-1:0] tgt_o
);
    logic [XLEN-1:0] sum;

    assign sum = base_i + ofs_i;

    // Choose at elaboration whether the low bit is cleared.
    generate
        if (CLEAR_LSB) begin : g_clr
            assign tgt_o = {sum[XLEN-1:1], 1'b0};
        end else begin : g_keep
            assign tgt_o = sum;
        end
    endgenerate
endmodule

// File: rtl/branch_jump_nextpc.sv
// Module: branch_jump_nextpc
// Computes the next fetch address, the return address and the taken flag.
// Assumes imm_i is already sign-extended and the design holds no state.
module branch_jump_nextpc
    import nxpc_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int INSN_LEN = 4
) (
    input  logic [XLEN-1:0]  pc_i,
    input  logic [XLEN-1:0]  rs1_i,
    input  logic [XLEN-1:0]  rs2_i,
    input  logic [XLEN-1:0]  imm_i,
    input  logic [OPC_W-1:0] opcode_i,
    input  logic [F3_W-1:0]  funct3_i,
    output logic [XLEN-1:0]  next_pc_o,
    output logic [XLEN-1:0]  link_o,
    output logic             taken_o
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_LEN);

    logic            eq, lt_s, lt_u, br_take;
    logic [XLEN-1:0] seq_pc, pcrel_tgt, regrel_tgt;
    sel_e            sel;

    assign seq_pc = pc_i + STEP;
    assign link_o = seq_pc;

    nxpc_compare #(.XLEN(XLEN)) u_cmp (
        .a_i(rs1_i), .b_i(rs2_i),
        .eq_o(eq), .lt_s_o(lt_s), .lt_u_o(lt_u)
    );

    nxpc_cond u_cond (
        .funct3_i(funct3_i), .eq_i(eq), .lt_s_i(lt_s), .lt_u_i(lt_u),
        .take_o(br_take)
    );

    nxpc_target #(.XLEN(XLEN), .CLEAR_LSB(1'b0)) u_pcrel (
        .base_i(pc_i), .ofs_i(imm_i), .tgt_o(pcrel_tgt)
    );

    nxpc_target #(.XLEN(XLEN), .CLEAR_LSB(1'b1)) u_regrel (
        .base_i(rs1_i), .ofs_i(imm_i), .tgt_o(regrel_tgt)
    );

    // Decode the opcode into a target source.
    always_comb begin
        sel = SEL_SEQ;
        if (opcode_i == OPC_JDIR)                  sel = SEL_PCREL;
        else if (opcode_i == OPC_JREG)             sel = SEL_REGREL;
        else if (opcode_i == OPC_BRANCH && br_take) sel = SEL_PCREL;
    end

    // Drive the next address and the taken flag from the selection.
    always_comb begin
        unique case (sel)
            SEL_PCREL:  next_pc_o = pcrel_tgt;
            SEL_REGREL: next_pc_o = regrel_tgt;
            default:    next_pc_o = seq_pc;
        endcase
        taken_o = (sel != SEL_SEQ);
    end

    // Check the opcode-level behaviour against the outputs.
    always_comb begin
        // R1
        seq_default_chk: assert (taken_o || next_pc_o == pc_i + STEP)
            else $error("fall-through address wrong");
        // R2
        jdir_taken_chk: assert (opcode_i != OPC_JDIR || taken_o)
            else $error("direct jump not taken");
        // R3
        jreg_lsb_chk: assert (opcode_i != OPC_JREG || next_pc_o[0] == 1'b0)
            else $error("register jump target odd");
    end
endmodule

// File: tb/branch_jump_nextpc_test.sv
module branch_jump_nextpc_test;
    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic [31:0] pc, rs1, rs2, imm, nxt, lnk;
    logic [6:0]  opc;
    logic [2:0]  f3;
    logic        tk;
    int checks = 0, fails = 0, cycles = 0;
    bit done = 0;

    branch_jump_nextpc uut (
        .pc_i(pc), .rs1_i(rs1), .rs2_i(rs2), .imm_i(imm),
        .opcode_i(opc), .funct3_i(f3),
        .next_pc_o(nxt), .link_o(lnk), .taken_o(tk)
    );

    task automatic apply(input logic [31:0] p, a, b, i,
                         input logic [6:0] o, input logic [2:0] f);
        @(negedge clk);
        pc = p; rs1 = a; rs2 = b; imm = i; opc = o; f3 = f;
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit exp_take(input logic [2:0] f, input logic [31:0] a, b);
        case (f)
            3'd0: return a == b;
            3'd1: return a != b;
            3'd4: return $signed(a) <  $signed(b);
            3'd5: return $signed(a) >= $signed(b);
            3'd6: return a <  b;
            3'd7: return a >= b;
            default: return 1'b0;
        endcase
    endfunction

    logic [31:0] vals [7] = '{32'h0, 32'h1, 32'h7fffffff, 32'h80000000,
                              32'hffffffff, 32'h5, 32'hfffffffb};

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: non-control opcode falls through
        apply(32'h1000, 32'h3, 32'h3, 32'h40, 7'b0110011, 3'd0);
        chk("R1", nxt, 32'h1004); chk("R1", {31'b0, tk}, 0);
        apply(32'h2000, 32'h0, 32'h0, 32'h8, 7'b0000011, 3'd0);
        chk("R1", nxt, 32'h2004);
        // R2: direct jump, backward and wrapping (R10)
        apply(32'h100, 32'h0, 32'h0, 32'hfffffff0, 7'b1101111, 3'd0);
        chk("R2", nxt, 32'hf0); chk("R2", {31'b0, tk}, 1);
        chk("R4", lnk, 32'h104);
        apply(32'hfffffffc, 32'h0, 32'h0, 32'h10, 7'b1101111, 3'd0);
        chk("R10", nxt, 32'h0000000c); chk("R10", lnk, 32'h0);
        // R3: register jump with odd sum; R4 link independent of rs1
        for (int k = 0; k < 4; k++) begin
            logic [31:0] a, i;
            a = 32'h3000 + k; i = 32'h11 + 2*k;
            apply(32'h500, a, 32'h0, i, 7'b1100111, 3'd0);
            chk("R3", nxt, (a + i) & ~32'h1); chk("R3", {31'b0, tk}, 1);
            chk("R4", lnk, 32'h504);
        end
        // R5 R6 R7 R8 R9: full operand/condition sweep
        for (int f = 0; f < 8; f++)
            for (int x = 0; x < 7; x++)
                for (int y = 0; y < 7; y++) begin
                    bit e;
                    string r;
                    e = exp_take(3'(f), vals[x], vals[y]);
                    r = (f < 2) ? "R5" : (f < 4) ? "R8" : (f < 6) ? "R6" : "R7";
                    apply(32'h8000, vals[x], vals[y], 32'h20, 7'b1100011, 3'(f));
                    chk(r, {31'b0, tk}, {31'b0, e});
                    chk("R9", nxt, e ? 32'h8020 : 32'h8004);
                end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule